// File: doc/BRIEF.md
# Zero-High-Bits Execution Unit

This unit is the integer datapath slice for a bit-manipulation operation that keeps the low part of a source word and clears everything from a chosen bit position upward. The bit position comes from the low byte of a second operand. If that position lies outside the active operand width, the source passes through whole and the carry flag is raised. The issue logic presents one operation per cycle with a valid strobe. One clock later, the unit returns either a registered result with its flags, or an undefined-opcode strobe when the encoding is illegal.

The operand width is 64 bits only when the core is in 64-bit mode and the width-select bit is set. In every other case the width is 32 bits, and the upper half of the result reads as zero.

Top module: `zhb_unit`

## Requirements
- R1: Only bits 7:0 of `idx_op` form the index N; bits 63:8 of `idx_op` have no effect on any output.
- R2: When N is less than the operand width W, result bits W-1 down to N are 0 and bits N-1 down to 0 equal `src_a`. N = 0 gives an all-zero result with `flag_zero` = 1.
- R3: When N > W-1, the result equals `src_a` restricted to W bits and `flag_carry` = 1; otherwise `flag_carry` = 0.
- R4: `flag_zero` is 1 exactly when the result is zero. `flag_sign` is result bit W-1, which is bit 63 for W = 64 and bit 31 for W = 32.
- R5: `flag_ovf`, `flag_adj` and `flag_par` always read 0.
- R6: With `long_mode` = 0, W is 32 whatever the value of `wide_sel`.
- R7: With `long_mode` = 1, W is 64 when `wide_sel` = 1 and 32 when `wide_sel` = 0.
- R8: When W = 32, result bits 63:32 are 0.
- R9: A valid input with `vlen_bit` = 1 gives `undef_exc` = 1 for one cycle on the next clock, with `out_valid` = 0 and the result and all flags held.
- R10: A valid input with `vlen_bit` = 0 gives `out_valid` = 1 on the next clock, for exactly one cycle. A cycle with no valid input gives `out_valid` = 0 and `undef_exc` = 0 on the next clock, and the result and flags hold their values.
- R11: Synchronous active-high `rst` clears `out_valid`, `undef_exc`, the result and all flags on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_a | input | 64 | Source word |
| idx_op | input | 64 | Index operand; only bits 7:0 are used |
| long_mode | input | 1 | 1 when the core is in 64-bit mode |
| wide_sel | input | 1 | Requests a 64-bit width |
| vlen_bit | input | 1 | Vector-length encoding bit; must be 0 |
| out_valid | output | 1 | Result and flags updated |
| result | output | 64 | Masked result |
| flag_zero | output | 1 | Result is zero |
| flag_carry | output | 1 | Index out of range |
| flag_sign | output | 1 | Top bit of the active width |
| flag_ovf | output | 1 | Overflow flag, always 0 |
| flag_adj | output | 1 | Adjust flag, driven 0 |
| flag_par | output | 1 | Parity flag, driven 0 |
| undef_exc | output | 1 | Illegal encoding strobe |

## Verification
A wrong width decision or a wrong mask shows up at the result and the flags one clock after the operation. The sharpest tests sit at the width boundaries: N = 31, 32, 63 and 64, an index with its upper bits set, and every combination of mode and width-select. A fault in the valid or exception registers shows up as a strobe that is missing, doubled or misplaced in the cycle right after the input. A fault in the hold logic shows up as a result or flag that changes after an illegal or idle cycle.

// File: rtl/zhb_unit.sv
module zhb_unit #(
  parameter int XLEN = 64,
  parameter int HALF = 32,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] idx_op,
  input  logic            long_mode,
  input  logic            wide_sel,
  input  logic            vlen_bit,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            flag_zero,
  output logic            flag_carry,
  output logic            flag_sign,
  output logic            flag_ovf,
  output logic            flag_adj,
  output logic            flag_par,
  output logic            undef_exc
);
  localparam logic [IDXW-1:0] TOPW = IDXW'(XLEN - 1);
  localparam logic [IDXW-1:0] TOPH = IDXW'(HALF - 1);

  logic            wide;
  logic [IDXW-1:0] n;
  logic            oor;
  logic [XLEN-1:0] keep;
  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] r_next;

  assign wide  = long_mode & wide_sel;
  assign n     = idx_op[IDXW-1:0];
  assign oor   = n > (wide ? TOPW : TOPH);
  assign wmask = wide ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

  for (genvar i = 0; i < XLEN; i++) begin : g_keep
    assign keep[i] = oor || (n > IDXW'(i));
  end

  assign r_next = src_a & keep & wmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      undef_exc  <= 1'b0;
      result     <= '0;
      flag_zero  <= 1'b0;
      flag_carry <= 1'b0;
      flag_sign  <= 1'b0;
    end else begin
      out_valid <= in_valid & ~vlen_bit;
      undef_exc <= in_valid & vlen_bit;
      if (in_valid && !vlen_bit) begin
        result     <= r_next;
        flag_zero  <= ~|r_next;
        flag_carry <= oor;
        flag_sign  <= wide ? r_next[XLEN-1] : r_next[HALF-1];
      end
    end
  end

  assign flag_ovf = 1'b0;
  assign flag_adj = 1'b0;
  assign flag_par = 1'b0;

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vlen_bit) |=> (out_valid && !undef_exc));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !undef_exc && $stable(result) && $stable(flag_carry)));

  a_r9_exc_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_bit) |=> (undef_exc && !out_valid && $stable(result)
                                && $stable(flag_zero) && $stable(flag_sign)));

  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_zero == (result == '0)));

  a_r8_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vlen_bit && !(long_mode && wide_sel)) |=> (result[XLEN-1:HALF] == '0));

  a_r3_carry_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vlen_bit && idx_op[IDXW-1:0] < 8'd32) |=> !flag_carry);

  a_r3_carry_big: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vlen_bit && idx_op[IDXW-1:0] > 8'd63) |=> (flag_carry && result == $past(src_a & wmask)));
endmodule

// File: tb/sim_zhb_unit.sv
module sim_zhb_unit;
  logic clk = 1'b0;
  logic rst, in_valid, long_mode, wide_sel, vlen_bit;
  logic [63:0] src_a, idx_op;
  logic out_valid, flag_zero, flag_carry, flag_sign, flag_ovf, flag_adj, flag_par, undef_exc;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  logic [63:0] e_res;
  logic e_ov, e_ex, e_z, e_c, e_s;

  always #4 clk = ~clk;

  zhb_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .idx_op(idx_op),
    .long_mode(long_mode), .wide_sel(wide_sel), .vlen_bit(vlen_bit),
    .out_valid(out_valid), .result(result), .flag_zero(flag_zero),
    .flag_carry(flag_carry), .flag_sign(flag_sign), .flag_ovf(flag_ovf),
    .flag_adj(flag_adj), .flag_par(flag_par), .undef_exc(undef_exc)
  );

  task automatic model(input logic r, input logic v, input logic [63:0] s, input logic [63:0] ix,
                       input logic lm, input logic ws, input logic vl);
    int w;
    int nn;
    logic [63:0] t;
    if (r) begin
      e_res = 0; e_ov = 0; e_ex = 0; e_z = 0; e_c = 0; e_s = 0;
    end else if (v && vl) begin
      e_ov = 0; e_ex = 1;
    end else if (v) begin
      w  = (lm && ws) ? 64 : 32;
      nn = int'(ix[7:0]);
      t  = 0;
      for (int i = 0; i < w; i++) if (i < nn) t[i] = s[i];
      e_res = t; e_ov = 1; e_ex = 0;
      e_c = (nn > w - 1);
      e_z = (t == 0);
      e_s = t[w-1];
    end else begin
      e_ov = 0; e_ex = 0;
    end
  endtask

  task automatic step(input string tag, input logic r, input logic v, input logic [63:0] s,
                      input logic [63:0] ix, input logic lm, input logic ws, input logic vl);
    @(negedge clk);
    rst = r; in_valid = v; src_a = s; idx_op = ix; long_mode = lm; wide_sel = ws; vlen_bit = vl;
    model(r, v, s, ix, lm, ws, vl);
    @(negedge clk);
    checks++;
    if (out_valid !== e_ov || undef_exc !== e_ex || result !== e_res || flag_zero !== e_z ||
        flag_carry !== e_c || flag_sign !== e_s || flag_ovf !== 1'b0 || flag_adj !== 1'b0 ||
        flag_par !== 1'b0) begin
      errors++;
      $display("FAIL %s: got v=%b x=%b r=%h z=%b c=%b s=%b o=%b a=%b p=%b exp v=%b x=%b r=%h z=%b c=%b s=%b o=0 a=0 p=0",
               tag, out_valid, undef_exc, result, flag_zero, flag_carry, flag_sign, flag_ovf,
               flag_adj, flag_par, e_ov, e_ex, e_res, e_z, e_c, e_s);
    end
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] P = 64'hF3C5_A96E_8D17_B24F;

  initial begin
    rst = 1; in_valid = 0; src_a = 0; idx_op = 0; long_mode = 0; wide_sel = 0; vlen_bit = 0;
    step("R11", 1, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 1, P, 5, 1, 1, 0);
    step("R2",  0, 1, P, 0, 1, 1, 0);
    step("R2",  0, 1, P, 5, 1, 1, 0);
    step("R2",  0, 1, P, 31, 1, 0, 0);
    step("R3",  0, 1, P, 32, 1, 0, 0);
    step("R3",  0, 1, P, 255, 1, 0, 0);
    step("R4",  0, 1, P, 63, 1, 1, 0);
    step("R3",  0, 1, P, 64, 1, 1, 0);
    step("R3",  0, 1, P, 200, 1, 1, 0);
    step("R4",  0, 1, 64'h8000_0000_0000_0000, 64, 1, 1, 0);
    step("R4",  0, 1, 64'h0000_0000_8000_0000, 32, 1, 0, 0);
    step("R4",  0, 1, 64'h0000_0000_8000_0000, 32, 1, 1, 0);
    step("R1",  0, 1, P, 64'hFFFF_FFFF_FFFF_FF03, 1, 1, 0);
    step("R1",  0, 1, P, 64'h0000_0000_0000_0103, 1, 1, 0);
    step("R6",  0, 1, P, 48, 0, 1, 0);
    step("R6",  0, 1, P, 20, 0, 0, 0);
    step("R7",  0, 1, P, 48, 1, 0, 0);
    step("R7",  0, 1, P, 48, 1, 1, 0);
    step("R8",  0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 40, 0, 0, 0);
    step("R8",  0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 200, 1, 0, 0);
    step("R2",  0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 37, 1, 1, 0);
    step("R9",  0, 1, 64'h1234_5678_9ABC_DEF0, 0, 1, 1, 1);
    step("R9",  0, 1, 0, 8, 0, 0, 1);
    step("R10", 0, 0, 64'h1111, 2, 1, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R10", 0, 1, 64'h00FF_00FF, 12, 1, 1, 0);
    step("R10", 0, 1, 64'h0F0F_0F0F, 9, 1, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    step("R5",  0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 0);
    for (int k = 0; k < 70; k++)
      step("R2", 0, 1, P ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15), 64'(k), 1, (k % 3) != 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule